// File: doc/BRIEF.md
# Address Breakpoint and Watchpoint Comparator

This block sits beside a processor core and watches two address streams: the instruction-fetch address, qualified by a fetch strobe, and the data memory address, qualified by separate read and write strobes. It holds a parameterised number of comparator units. Each unit has two programmable addresses and a control word. When an access of an enabled kind hits a programmed address, the unit raises its own sticky pending flag, and the block as a whole pulses a halt request towards the core.

A unit can compare in one of two ways. In point mode each of its two addresses is an independent match target. In range mode any address within the inclusive window from the first address to the second address matches. Range mode is a build-time option: with it compiled out, the range-select control bit is ignored and the unit always compares in point mode. A debugger programs the units through a simple single-cycle write port. The same port acknowledges a pending flag by writing 1 to it.

Top module: `brkpt_watch`

## Requirements
- R1: After reset every pending flag and the halt request are 0. Every unit's control word and addresses reset to 0.
- R2: A unit whose control bit 2 (unit enable) is 0 never matches any access, whatever its other control bits hold.
- R3: With control bits 2 and 0 set, a data read (mem_rd_i) whose address equals either programmed address sets that unit's pending flag. The flag is visible after the clock edge that samples the read.
- R4: With control bits 2 and 1 set, a data write (mem_wr_i) whose address equals either programmed address sets that unit's pending flag. The flag is visible after the sampling edge.
- R5: With control bits 2 and 3 set, an instruction fetch (fetch_vld_i) whose fetch address equals either programmed address sets that unit's pending flag.
- R6: An address match counts only when the strobe of a kind that is enabled in the control word is active. An equal address with no strobe does not set a flag. An equal address under a strobe of a kind that is not enabled also does not set a flag.
- R7: With range mode built in, control bit 4 makes the unit match any enabled access whose address A satisfies addr0 <= A <= addr1, both ends included. Addresses outside that window do not match.
- R8: With range mode left out of the build, control bit 4 has no effect and the unit compares in point mode.
- R9: Pending flags are sticky. Writing register select 3 with data bit 0 = 1 clears the addressed unit's flag. Writing data bit 0 = 0 leaves it unchanged.
- R10: halt_req_o is 1 during the cycle that follows each sampled matching access and 0 otherwise. Back-to-back matching accesses keep it high.
- R11: When a match and a clear of the same unit occur in the same cycle, the flag ends up set.
- R12: Units are independent. A match in one unit sets only that unit's flag, at bit index equal to the unit number.
- R13: Register select encoding on cfg_reg_i: 0 is the control word, 1 is addr0, 2 is addr1, 3 is the pending acknowledge. A write takes effect for accesses sampled from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_addr_i | input | ADDR_W | Instruction-fetch address |
| fetch_vld_i | input | 1 | Fetch strobe |
| mem_addr_i | input | ADDR_W | Data memory address |
| mem_rd_i | input | 1 | Data read strobe |
| mem_wr_i | input | 1 | Data write strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_unit_i | input | UNIT_W | Unit selected by the write |
| cfg_reg_i | input | 2 | Register select within the unit |
| cfg_wdata_i | input | ADDR_W | Write data |
| halt_req_o | output | 1 | One-cycle halt request per matching cycle |
| hit_pend_o | output | NUM_UNITS | Sticky pending flag per unit |

## Verification
Address comparison is combinational from registered configuration, and the pending flags and halt request are each one register deep. Every result is therefore due exactly one clock edge after the access that causes it. The bench drives strobes on the falling edge and removes them on the next falling edge. Its check comes at that second falling edge, half a cycle after the sampling edge. It then waits one more falling edge to confirm that the halt pulse has ended while the flag is held. Configuration writes are completed one full cycle before the access they are meant to affect. The one exception is the set-versus-clear case, which deliberately puts the acknowledge and the access in the same cycle.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

  // control word bit positions
  localparam int unsigned CB_RD    = 0;
  localparam int unsigned CB_WR    = 1;
  localparam int unsigned CB_EN    = 2;
  localparam int unsigned CB_FETCH = 3;
  localparam int unsigned CB_RANGE = 4;
  localparam int unsigned CTRL_W   = 5;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LO   = 2'd1,
    REG_HI   = 2'd2,
    REG_ACK  = 2'd3
  } brk_reg_e;

  typedef struct packed {
    logic range_sel;
    logic fetch_en;
    logic unit_en;
    logic wr_en;
    logic rd_en;
  } brk_ctrl_t;

endpackage

// File: rtl/brkpt_cmp.sv
module brkpt_cmp #(
  parameter int unsigned ADDR_W   = 16,
  parameter bit          RANGE_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic              range_sel_i,
  output logic              hit_o
);

  logic point_hit;
  assign point_hit = (addr_i == lo_i) || (addr_i == hi_i);

  generate
    if (RANGE_EN) begin : g_range
      logic in_win;
      assign in_win = (addr_i >= lo_i) && (addr_i <= hi_i);
      assign hit_o  = range_sel_i ? in_win : point_hit;
    end else begin : g_point
      logic unused_sel;
      assign unused_sel = range_sel_i;
      assign hit_o      = point_hit;
    end
  endgenerate

endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
  import brkpt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter bit          RANGE_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [1:0]        reg_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              fetch_vld_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              mem_rd_i,
  input  logic              mem_wr_i,
  output logic              hit_o,
  output logic              pend_o
);

  brk_ctrl_t         ctrl_q;
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic              pend_q;
  brk_reg_e          reg_sel;

  assign reg_sel = brk_reg_e'(reg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (sel_i) begin
      case (reg_sel)
        REG_CTRL: ctrl_q <= brk_ctrl_t'(wdata_i[CTRL_W-1:0]);
        REG_LO:   lo_q   <= wdata_i;
        REG_HI:   hi_q   <= wdata_i;
        default:  ;
      endcase
    end
  end

  logic fetch_cmp, mem_cmp;

  brkpt_cmp #(.ADDR_W(ADDR_W), .RANGE_EN(RANGE_EN)) u_cmp_fetch (
    .addr_i      (fetch_addr_i),
    .lo_i        (lo_q),
    .hi_i        (hi_q),
    .range_sel_i (ctrl_q.range_sel),
    .hit_o       (fetch_cmp)
  );

  brkpt_cmp #(.ADDR_W(ADDR_W), .RANGE_EN(RANGE_EN)) u_cmp_mem (
    .addr_i      (mem_addr_i),
    .lo_i        (lo_q),
    .hi_i        (hi_q),
    .range_sel_i (ctrl_q.range_sel),
    .hit_o       (mem_cmp)
  );

  logic fetch_hit, rd_hit, wr_hit;
  assign fetch_hit = ctrl_q.fetch_en && fetch_vld_i && fetch_cmp;
  assign rd_hit    = ctrl_q.rd_en    && mem_rd_i    && mem_cmp;
  assign wr_hit    = ctrl_q.wr_en    && mem_wr_i    && mem_cmp;
  assign hit_o     = ctrl_q.unit_en && (fetch_hit || rd_hit || wr_hit);

  logic ack;
  assign ack = sel_i && (reg_sel == REG_ACK) && wdata_i[0];

  // set has priority over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (hit_o) pend_q <= 1'b1;
    else if (ack)   pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/brkpt_watch.sv
module brkpt_watch #(
  parameter int unsigned NUM_UNITS = 2,
  parameter int unsigned ADDR_W    = 16,
  parameter bit          RANGE_EN  = 1'b1,
  localparam int unsigned UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    fetch_addr_i,
  input  logic                 fetch_vld_i,
  input  logic [ADDR_W-1:0]    mem_addr_i,
  input  logic                 mem_rd_i,
  input  logic                 mem_wr_i,
  input  logic                 cfg_we_i,
  input  logic [UNIT_W-1:0]    cfg_unit_i,
  input  logic [1:0]           cfg_reg_i,
  input  logic [ADDR_W-1:0]    cfg_wdata_i,
  output logic                 halt_req_o,
  output logic [NUM_UNITS-1:0] hit_pend_o
);

  logic [NUM_UNITS-1:0] hit_vec;

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_unit
    logic sel;
    assign sel = cfg_we_i && (cfg_unit_i == UNIT_W'(k));

    brkpt_unit #(.ADDR_W(ADDR_W), .RANGE_EN(RANGE_EN)) u_unit (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sel_i        (sel),
      .reg_i        (cfg_reg_i),
      .wdata_i      (cfg_wdata_i),
      .fetch_addr_i (fetch_addr_i),
      .fetch_vld_i  (fetch_vld_i),
      .mem_addr_i   (mem_addr_i),
      .mem_rd_i     (mem_rd_i),
      .mem_wr_i     (mem_wr_i),
      .hit_o        (hit_vec[k]),
      .pend_o       (hit_pend_o[k])
    );
  end

  logic halt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= 1'b0;
    else         halt_q <= |hit_vec;
  end

  assign halt_req_o = halt_q;

endmodule

// File: rtl/brkpt_watch_chk.sv
module brkpt_watch_chk #(
  parameter int unsigned NUM_UNITS = 2,
  parameter int unsigned UNIT_W    = 1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 fetch_vld_i,
  input logic                 mem_rd_i,
  input logic                 mem_wr_i,
  input logic                 cfg_we_i,
  input logic [UNIT_W-1:0]    cfg_unit_i,
  input logic [1:0]           cfg_reg_i,
  input logic                 halt_req_o,
  input logic [NUM_UNITS-1:0] hit_pend_o
);

  logic any_strobe, ack_wr;
  assign any_strobe = fetch_vld_i || mem_rd_i || mem_wr_i;
  assign ack_wr     = cfg_we_i && (cfg_reg_i == 2'd3);

  AST_HALT_WITH_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_req_o |-> (hit_pend_o != '0)); // R3

  AST_NO_STROBE_NO_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_strobe |=> !halt_req_o); // R6

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_wr |=> ((hit_pend_o & $past(hit_pend_o)) == $past(hit_pend_o))); // R9

  AST_NEW_PEND_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit_pend_o & ~$past(hit_pend_o)) != '0) |-> halt_req_o); // R10

  AST_NO_STROBE_NO_NEW_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_strobe |=> ((hit_pend_o & ~$past(hit_pend_o)) == '0)); // R6

  AST_PEND_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({halt_req_o, hit_pend_o})); // R1

  logic unused_unit;
  assign unused_unit = ^cfg_unit_i;

endmodule

bind brkpt_watch brkpt_watch_chk #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_vld_i (fetch_vld_i),
  .mem_rd_i    (mem_rd_i),
  .mem_wr_i    (mem_wr_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_unit_i  (cfg_unit_i),
  .cfg_reg_i   (cfg_reg_i),
  .halt_req_o  (halt_req_o),
  .hit_pend_o  (hit_pend_o)
);

// File: tb/brkpt_watch_bench.sv
`timescale 1ns/1ps
module brkpt_watch_bench;

  localparam int unsigned NU = 2;
  localparam int unsigned AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_vld = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic          mem_rd = 1'b0;
  logic          mem_wr = 1'b0;
  logic          cfg_we = 1'b0;
  logic [0:0]    cfg_unit = '0;
  logic [1:0]    cfg_reg = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          halt, halt_nr;
  logic [NU-1:0] pend, pend_nr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  brkpt_watch #(.NUM_UNITS(NU), .ADDR_W(AW), .RANGE_EN(1'b1)) u_brkpt_watch (
    .clk_i(clk), .rst_ni(rst_n), .fetch_addr_i(fetch_addr), .fetch_vld_i(fetch_vld),
    .mem_addr_i(mem_addr), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .cfg_we_i(cfg_we),
    .cfg_unit_i(cfg_unit), .cfg_reg_i(cfg_reg), .cfg_wdata_i(cfg_wdata),
    .halt_req_o(halt), .hit_pend_o(pend));

  brkpt_watch #(.NUM_UNITS(NU), .ADDR_W(AW), .RANGE_EN(1'b0)) u_brkpt_watch_nr (
    .clk_i(clk), .rst_ni(rst_n), .fetch_addr_i(fetch_addr), .fetch_vld_i(fetch_vld),
    .mem_addr_i(mem_addr), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .cfg_we_i(cfg_we),
    .cfg_unit_i(cfg_unit), .cfg_reg_i(cfg_reg), .cfg_wdata_i(cfg_wdata),
    .halt_req_o(halt_nr), .hit_pend_o(pend_nr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input int u, input logic [1:0] r, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_unit = u[0:0]; cfg_reg = r; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ack(input int u);
    cfg_wr(u, 2'd3, 16'h0001);
  endtask

  // kind: 0 read, 1 write, 2 fetch, 3 address only (no strobe)
  task automatic access(input int kind, input logic [AW-1:0] a);
    @(negedge clk);
    mem_addr = a; fetch_addr = a;
    mem_rd = (kind == 0); mem_wr = (kind == 1); fetch_vld = (kind == 2);
    @(negedge clk);
    mem_rd = 1'b0; mem_wr = 1'b0; fetch_vld = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pend", 32'(pend), 0);
    chk("R1 halt", 32'(halt), 0);
  endtask

  task automatic t_disabled;
    cfg_wr(0, 2'd1, 16'h0040);
    cfg_wr(0, 2'd0, 16'h000B);
    access(0, 16'h0040); access(1, 16'h0040); access(2, 16'h0040);
    chk("R2 disabled unit", 32'(pend), 0);
  endtask

  task automatic t_read;
    cfg_wr(0, 2'd2, 16'h0080);
    cfg_wr(0, 2'd0, 16'h0005);
    access(0, 16'h0080);
    chk("R3 read addr1 pend", 32'(pend), 1);
    chk("R10 halt pulse", 32'(halt), 1);
    @(negedge clk);
    chk("R10 halt ends", 32'(halt), 0);
    ack(0);
    access(0, 16'h0040);
    chk("R3 read addr0 pend", 32'(pend), 1);
    ack(0);
    access(0, 16'h0041);
    chk("R3 read miss", 32'(pend), 0);
  endtask

  task automatic t_write;
    cfg_wr(0, 2'd0, 16'h0006);
    access(0, 16'h0040);
    chk("R6 read not enabled", 32'(pend), 0);
    access(1, 16'h0040);
    chk("R4 write hit", 32'(pend), 1);
    ack(0);
  endtask

  task automatic t_fetch;
    cfg_wr(0, 2'd0, 16'h000C);
    access(0, 16'h0080);
    chk("R6 read with fetch only", 32'(pend), 0);
    access(3, 16'h0080);
    chk("R6 no strobe", 32'(pend), 0);
    chk("R6 no strobe halt", 32'(halt), 0);
    access(2, 16'h0080);
    chk("R5 fetch hit", 32'(pend), 1);
    ack(0);
  endtask

  task automatic t_sticky;
    cfg_wr(0, 2'd0, 16'h0005);
    access(0, 16'h0040);
    repeat (3) @(negedge clk);
    chk("R9 sticky", 32'(pend), 1);
    cfg_wr(0, 2'd3, 16'h0000);
    chk("R9 ack zero ignored", 32'(pend), 1);
    cfg_wr(0, 2'd3, 16'h0001);
    chk("R9 ack clears", 32'(pend), 0);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    cfg_we = 1'b1; cfg_unit = 1'b0; cfg_reg = 2'd3; cfg_wdata = 16'h0001;
    mem_addr = 16'h0040; mem_rd = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; mem_rd = 1'b0;
    chk("R11 set over clear", 32'(pend), 1);
    ack(0);
  endtask

  task automatic t_units;
    cfg_wr(1, 2'd1, 16'h0200);
    cfg_wr(1, 2'd2, 16'h0300);
    cfg_wr(1, 2'd0, 16'h0005);
    access(0, 16'h0200);
    chk("R12 unit1 only", 32'(pend), 2);
    ack(1);
    chk("R13 ack selects unit", 32'(pend), 0);
    @(negedge clk);
    mem_addr = 16'h0300; mem_rd = 1'b1;
    @(negedge clk);
    mem_addr = 16'h0040;
    @(negedge clk);
    mem_rd = 1'b0;
    chk("R10 back-to-back halt", 32'(halt), 1);
    chk("R12 both units", 32'(pend), 3);
    ack(0); ack(1);
  endtask

  task automatic t_range;
    cfg_wr(1, 2'd1, 16'h0100);
    cfg_wr(1, 2'd2, 16'h010F);
    cfg_wr(1, 2'd0, 16'h0015);
    access(0, 16'h0100);
    chk("R7 low end", 32'(pend), 2);
    chk("R8 low end point", 32'(pend_nr), 2);
    ack(1);
    access(0, 16'h010F);
    chk("R7 high end", 32'(pend), 2);
    ack(1);
    access(0, 16'h0108);
    chk("R7 inside", 32'(pend), 2);
    chk("R8 inside ignored", 32'(pend_nr), 0);
    chk("R8 no halt", 32'(halt_nr), 0);
    ack(1);
    access(0, 16'h00FF);
    chk("R7 below", 32'(pend), 0);
    access(0, 16'h0110);
    chk("R7 above", 32'(pend), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_disabled;
    t_read;
    t_write;
    t_fetch;
    t_sticky;
    t_set_wins;
    t_units;
    t_range;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule